// File: doc/BRIEF.md
# Latch-Width Serial Shifter

This block drives a daisy-chain of shift-register LED drivers over three wires: a serial clock, a serial data line and a latch-enable strobe. A host asks for a frame by giving a length in bits, a latch width N and a half-period for the serial clock. It then supplies the frame bits one at a time through a valid/ready stream. The frame length has single-bit granularity. One frame holds the bits for every driver in the chain, joined end to end.

The receiving drivers read the number of clock pulses that see latch-enable high as a command. For that reason the strobe is not a chip select that follows the frame. It is raised inside the frame and covers exactly the last N serial clock pulses. One sequencer produces clock, data and strobe from a single system-clock counter, so the strobe cannot drift into a neighbouring pulse. A stall in the bit stream parks the clock low and the alignment is unaffected. A request with an invalid latch width is refused at the handshake and nothing is sent.

Top module: `ledchain_shifter`

## Requirements
- R1: An accepted frame of length L produces exactly L rising edges of `sclk`. After the last one `sclk` stays low until the next frame.
- R2: Bits go out in arrival order, so the host sends the most significant bit first. `sdo` carries the k-th accepted bit at the k-th rising edge of `sclk` and changes only while `sclk` is low.
- R3: For a latch width N between 1 and L, `lat_en` is high at rising edges L-N+1 through L of the frame and low at every earlier rising edge. N = 3 is the usual case.
- R4: `lat_en` changes only while `sclk` is low, so its level is constant across every high phase of `sclk`.
- R5: A latch width of 0 sends the frame with `lat_en` low throughout.
- R6: A request with length 0, or with a latch width greater than the length, completes its handshake and is refused. `err` is high for exactly the one cycle after it, `busy` stays low and no `sclk` edge is produced.
- R7: Each high phase of `sclk` lasts `cfg_half` system clocks, and a value of 0 counts as 1. Each low phase between pulses lasts at least `cfg_half`+1 system clocks.
- R8: While the block is waiting for a bit (`bit_ready` high), `sclk` is low. A stalled bit stream delays the pulses but leaves the data and the latch alignment unchanged.
- R9: `busy` rises in the cycle after a valid request is accepted. It falls `cfg_half` system clocks (at least 1) after the final falling edge of `sclk`. `req_ready` is high exactly when `busy` is low.
- R10: While `busy` is low, `sclk`, `sdo` and `lat_en` are all low. This includes the state after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Frame request offered |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_len | input | LEN_W | Frame length in bits |
| req_lat | input | LAT_W | Latch width N: count of final pulses with strobe high |
| cfg_half | input | DIV_W | Serial clock half-period in system clocks, captured with the request |
| bit_valid | input | 1 | A frame bit is offered |
| bit_ready | output | 1 | Block takes the offered bit |
| bit_data | input | 1 | Frame bit value |
| sclk | output | 1 | Serial clock to the chain |
| sdo | output | 1 | Serial data to the chain |
| lat_en | output | 1 | Latch-enable strobe to the chain |
| busy | output | 1 | Frame in progress |
| err | output | 1 | One-cycle pulse after a refused request |

## Verification
The frames sent differ in length (byte-aligned, odd and single-bit), in latch width (0, 1, the usual 3, a middle value and equal to the length) and in bit pattern. A strobe that is one pulse too wide, one pulse too narrow or shifted by one shows up as a wrong count or a wrong position, and a reversed bit order shows up as a data mismatch. A frame whose bit stream has gaps is compared with the same frame sent without gaps, which separates a stall from a misalignment. Requests that are refused, and a zero half-period, cover the edges of the request check and of the divider.

// File: rtl/ledchain_pkg.sv
// Shared types for the latch-width serial shifter.
package ledchain_pkg;
    // Sequencer states: idle, waiting for a bit, clock low, clock high, idle tail.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_TAIL
    } sh_state_t;
endpackage

// File: rtl/ledchain_halfcnt.sv
// Half-period counter for the serial clock.
// A load sets it to the programmed half-period. After that it counts down
// once per system clock. done is high in the last cycle of the phase.
// Assumes: a half-period of 0 behaves as 1.
module ledchain_halfcnt #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] half,
    output logic             done
);
    logic [DIV_W-1:0] cnt;

    // Reload at a phase start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= half;
        else if (cnt != '0)
            cnt <= cnt - {{(DIV_W-1){1'b0}}, 1'b1};
    end

    // The phase ends when the count has reached one (or was loaded as zero).
    assign done = (cnt <= {{(DIV_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/ledchain_reqchk.sv
// Checks a frame request.
// A request is valid when the length is non-zero and the latch width
// does not exceed the length.
// Assumes: LAT_W <= LEN_W.
module ledchain_reqchk #(
    parameter int LEN_W = 16,
    parameter int LAT_W = 4
) (
    input  logic [LEN_W-1:0] len,
    input  logic [LAT_W-1:0] lat,
    output logic             ok
);
    logic [LEN_W-1:0] lat_ext;

    // Widen the latch width to the length width and compare.
    always_comb begin
        lat_ext = LEN_W'(lat);
        ok      = (len != '0) && (lat_ext <= len);
    end
endmodule

// File: rtl/ledchain_ctl.sv
// Frame sequencer. It takes a request, pulls one bit per serial pulse,
// and drives sclk, sdo and lat_en from one state register. This keeps the
// strobe aligned to the pulse count. Data and strobe are updated only in
// the cycle where a bit is taken, or at the end of the tail, and sclk is
// low at both of those points.
// Assumes: the request was checked by ledchain_reqchk. tick_done comes
// from a counter that is reloaded through tick_load.
module ledchain_ctl
    import ledchain_pkg::*;
#(
    parameter int LEN_W = 16,
    parameter int LAT_W = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_ok,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LAT_W-1:0] req_lat,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             bit_valid,
    input  logic             bit_data,
    input  logic             tick_done,
    output logic             tick_load,
    output logic [DIV_W-1:0] half_q,
    output logic             req_ready,
    output logic             bit_ready,
    output logic             sclk,
    output logic             sdo,
    output logic             lat_en,
    output logic             busy,
    output logic             err
);
    localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

    sh_state_t        st;
    logic [LEN_W-1:0] rem;
    logic [LAT_W-1:0] latw;
    logic             take;
    logic             in_window;

    // Handshake and phase-reload decode.
    always_comb begin
        busy      = (st != ST_IDLE);
        req_ready = !busy;
        bit_ready = (st == ST_FETCH);
        take      = bit_ready && bit_valid;
        tick_load = take || (((st == ST_LOW) || (st == ST_HIGH)) && tick_done);
        in_window = (rem <= LEN_W'(latw));
    end

    // Sequencer: accept a request, then per bit: fetch, low phase, high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            rem    <= '0;
            latw   <= '0;
            half_q <= '0;
            sclk   <= 1'b0;
            sdo    <= 1'b0;
            lat_en <= 1'b0;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_ok) begin
                            rem    <= req_len;
                            latw   <= req_lat;
                            half_q <= cfg_half;
                            st     <= ST_FETCH;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_FETCH: begin
                    if (bit_valid) begin
                        sdo    <= bit_data;
                        lat_en <= in_window;
                        st     <= ST_LOW;
                    end
                end
                ST_LOW: begin
                    if (tick_done) begin
                        sclk <= 1'b1;
                        st   <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tick_done) begin
                        sclk <= 1'b0;
                        rem  <= rem - LEN_ONE;
                        st   <= (rem == LEN_ONE) ? ST_TAIL : ST_FETCH;
                    end
                end
                ST_TAIL: begin
                    if (tick_done) begin
                        sdo    <= 1'b0;
                        lat_en <= 1'b0;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ledchain_shifter.sv
// Top level of the latch-width serial shifter. It joins the request
// check, the frame sequencer and the half-period counter.
// Assumes: LAT_W <= LEN_W, and inputs synchronous to clk.
module ledchain_shifter #(
    parameter int LEN_W = 16,
    parameter int LAT_W = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [LEN_W-1:0] req_len,
    input  logic [LAT_W-1:0] req_lat,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             bit_valid,
    output logic             bit_ready,
    input  logic             bit_data,
    output logic             sclk,
    output logic             sdo,
    output logic             lat_en,
    output logic             busy,
    output logic             err
);
    logic             req_ok;
    logic             tick_load;
    logic             tick_done;
    logic [DIV_W-1:0] half_q;

    ledchain_reqchk #(.LEN_W(LEN_W), .LAT_W(LAT_W)) u_reqchk (
        .len (req_len),
        .lat (req_lat),
        .ok  (req_ok)
    );

    ledchain_halfcnt #(.DIV_W(DIV_W)) u_halfcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tick_load),
        .half  (half_q),
        .done  (tick_done)
    );

    ledchain_ctl #(.LEN_W(LEN_W), .LAT_W(LAT_W), .DIV_W(DIV_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ok    (req_ok),
        .req_len   (req_len),
        .req_lat   (req_lat),
        .cfg_half  (cfg_half),
        .bit_valid (bit_valid),
        .bit_data  (bit_data),
        .tick_done (tick_done),
        .tick_load (tick_load),
        .half_q    (half_q),
        .req_ready (req_ready),
        .bit_ready (bit_ready),
        .sclk      (sclk),
        .sdo       (sdo),
        .lat_en    (lat_en),
        .busy      (busy),
        .err       (err)
    );
endmodule

// File: rtl/ledchain_shifter_chk.sv
// Protocol checker for ledchain_shifter. It is attached through bind and
// watches only the top-level ports.
module ledchain_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic bit_ready,
    input logic sclk,
    input logic sdo,
    input logic lat_en,
    input logic busy,
    input logic err
);
    // R4: the strobe moves only when sclk is low before and after the change.
    a_r4_lat_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_en) |-> (!sclk && !$past(sclk)));

    // R2: data moves only when sclk is low before and after the change.
    a_r2_sdo_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo) |-> (!sclk && !$past(sclk)));

    // R10: all pins are low whenever no frame is in progress.
    a_r10_idle_pins_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && !sdo && !lat_en));

    // R8: sclk is parked low while the block waits for a bit.
    a_r8_stall_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        bit_ready |-> !sclk);

    // R6: an error pulse follows a completed handshake and leaves the block idle.
    a_r6_err_after_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && $past(req_valid && req_ready)));
endmodule

bind ledchain_shifter ledchain_shifter_chk u_chk (.*);

// File: tb/tb_ledchain_shifter.sv
`timescale 1ns/1ps
module tb_ledchain_shifter;
    localparam int LEN_W = 16;
    localparam int LAT_W = 4;
    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [LEN_W-1:0] req_len = '0;
    logic [LAT_W-1:0] req_lat = '0;
    logic [DIV_W-1:0] cfg_half = '0;
    logic             bit_valid = 1'b0;
    logic             bit_ready;
    logic             bit_data = 1'b0;
    logic             sclk, sdo, lat_en, busy, err;

    int n_chk = 0;
    int n_bad = 0;

    // monitor state
    int   cyc = 0;
    int   n_edge = 0;
    logic cap_d [64];
    logic cap_l [64];
    int   hi_run = 0;
    int   last_hi = 0;
    int   fall_cyc = 0;
    int   busy_fall = 0;
    int   busy_rise_n = 0;
    int   err_n = 0;
    int   stall_bad = 0;
    int   lat_hi_chg = 0;
    logic fall_pins = 1'b0;
    logic p_sclk = 1'b0;
    logic p_busy = 1'b0;
    logic p_lat = 1'b0;
    logic acc_busy = 1'b0;

    always #4 clk = ~clk;

    ledchain_shifter #(.LEN_W(LEN_W), .LAT_W(LAT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .req_lat(req_lat), .cfg_half(cfg_half),
        .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
        .sclk(sclk), .sdo(sdo), .lat_en(lat_en), .busy(busy), .err(err)
    );

    // Port monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (sclk && !p_sclk) begin
            if (n_edge < 64) begin
                cap_d[n_edge] = sdo;
                cap_l[n_edge] = lat_en;
            end
            n_edge = n_edge + 1;
            hi_run = 1;
        end else if (sclk) begin
            hi_run = hi_run + 1;
            if (lat_en != p_lat) lat_hi_chg = lat_hi_chg + 1;
        end
        if (!sclk && p_sclk) begin
            last_hi  = hi_run;
            fall_cyc = cyc;
        end
        if (p_busy && !busy) begin
            busy_fall = cyc;
            fall_pins = sclk | sdo | lat_en;
        end
        if (!p_busy && busy) busy_rise_n = busy_rise_n + 1;
        if (err) err_n = err_n + 1;
        if (bit_ready && sclk) stall_bad = stall_bad + 1;
        p_sclk = sclk;
        p_busy = busy;
        p_lat  = lat_en;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1600000;
        n_chk = n_chk + 1;
        n_bad = n_bad + 1;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_edge = 0; last_hi = 0; fall_cyc = 0; busy_fall = 0; busy_rise_n = 0;
        err_n = 0; stall_bad = 0; lat_hi_chg = 0; fall_pins = 1'b0;
    endtask

    // Offer a request and wait for the handshake.
    task automatic send_req(input int len, input int latw, input int half);
        @(negedge clk);
        clear_mon();
        req_valid = 1'b1;
        req_len   = LEN_W'(len);
        req_lat   = LAT_W'(latw);
        cfg_half  = DIV_W'(half);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        acc_busy  = busy;
        req_valid = 1'b0;
    endtask

    // Send a full frame: request, bits first-to-last from bits[len-1] down, gaps between bits.
    task automatic run_frame(input int len, input int latw, input int half,
                             input logic [63:0] bits, input int gap);
        send_req(len, latw, half);
        for (int i = 0; i < len; i++) begin
            repeat (gap) @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = bits[len-1-i];
            while (!bit_ready) @(negedge clk);
            @(negedge clk);
            bit_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Compare captured data and strobe against the frame description.
    task automatic check_frame(input string name, input int len, input int latw,
                               input int half, input logic [63:0] bits);
        int d_bad = 0;
        int l_bad = 0;
        int l_ones = 0;
        int eh = (half == 0) ? 1 : half;
        check(n_edge == len, {name, " R1 rising edges"}, n_edge, len);
        for (int k = 0; k < len && k < 64; k++) begin
            if (cap_d[k] !== bits[len-1-k]) d_bad++;
            if (cap_l[k] !== (k >= len - latw)) l_bad++;
            if (cap_l[k] === 1'b1) l_ones++;
        end
        check(d_bad == 0, {name, " R2 data order"}, d_bad, 0);
        check(l_bad == 0, {name, " R3 strobe position"}, l_bad, 0);
        check(l_ones == latw, {name, " R3 strobe width"}, l_ones, latw);
        check(lat_hi_chg == 0, {name, " R4 strobe steady while sclk high"}, lat_hi_chg, 0);
        check(last_hi == eh, {name, " R7 high phase"}, last_hi, eh);
        check(acc_busy == 1'b1, {name, " R9 busy after accept"}, acc_busy, 1);
        check(busy_fall - fall_cyc == eh, {name, " R9 tail length"}, busy_fall - fall_cyc, eh);
        check(fall_pins == 1'b0, {name, " R10 pins low at frame end"}, fall_pins, 0);
    endtask

    task automatic t_reset();
        check(!sclk && !sdo && !lat_en, "R10 pins after reset", {sclk, sdo, lat_en}, 0);
        check(!busy && req_ready, "R9 idle handshake after reset", {busy, req_ready}, 1);
        check(!err, "R6 no error after reset", err, 0);
    endtask

    task automatic t_default_latch();
        logic [63:0] b = 64'h0000_0000_00A5_3C96;
        run_frame(24, 3, 3, b, 0);
        check_frame("default N3", 24, 3, 3, b);
    endtask

    task automatic t_odd_length();
        logic [63:0] b = 64'h0000_0000_0000_1B2D;
        run_frame(13, 5, 1, b, 0);
        check_frame("odd L13 N5", 13, 5, 1, b);
    endtask

    task automatic t_no_latch();
        logic [63:0] b = 64'h0000_0000_0000_0FF0;
        run_frame(16, 0, 2, b, 0);
        check_frame("R5 N0", 16, 0, 2, b);
    endtask

    task automatic t_full_latch();
        logic [63:0] b = 64'h0000_0000_0000_0009;
        run_frame(4, 4, 2, b, 0);
        check_frame("R3 N equals L", 4, 4, 2, b);
    endtask

    task automatic t_single_bit();
        logic [63:0] b = 64'h1;
        run_frame(1, 1, 4, b, 0);
        check_frame("R3 L1 N1", 1, 1, 4, b);
    endtask

    task automatic t_stall();
        logic [63:0] b = 64'h0000_0000_0000_6D5A;
        run_frame(15, 3, 2, b, 5);
        check_frame("R8 stalled stream", 15, 3, 2, b);
        check(stall_bad == 0, "R8 sclk low while waiting", stall_bad, 0);
    endtask

    task automatic t_zero_half();
        logic [63:0] b = 64'h0000_0000_0000_00C3;
        run_frame(8, 2, 0, b, 0);
        check_frame("R7 zero half-period", 8, 2, 0, b);
    endtask

    task automatic t_reject();
        send_req(4, 5, 2);
        repeat (10) @(negedge clk);
        check(err_n == 1, "R6 error pulse N>L", err_n, 1);
        check(busy_rise_n == 0, "R6 busy stays low N>L", busy_rise_n, 0);
        check(n_edge == 0, "R6 no clock N>L", n_edge, 0);
        send_req(0, 0, 2);
        repeat (10) @(negedge clk);
        check(err_n == 1, "R6 error pulse L0", err_n, 1);
        check(n_edge == 0 && busy_rise_n == 0, "R6 nothing sent L0", n_edge + busy_rise_n, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_default_latch();
        t_odd_length();
        t_no_latch();
        t_full_latch();
        t_single_bit();
        t_stall();
        t_zero_half();
        t_reject();
        t_default_latch();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule